// File: doc/BRIEF.md
# Dual-Sample Conversion Sequencer

This block is the timing controller that sits between a host-written control register and a successive-approximation bit-decision engine. A start pulse begins a sequence. The host raises this pulse when a control write completes. The sequence opens with an acquisition phase of fixed length and ends it with a one-cycle hold strobe. It then runs one conversion phase, or two back to back. For each phase the block tells the engine which source to convert. At the end of each phase it raises a load strobe, which moves that result into result register 1 or result register 2.

The block also drives an active-low status pin. A mode input selects one of two meanings for it:

- **Busy:** the pin is low while a sequence runs.
- **Interrupt:** the pin goes low once a sequence completes and stays low until the next host access.

Host accesses interact with a running sequence as follows:

- A write during a sequence restarts it.
- A read during a sequence cancels it.
- A power-down level ends any sequence at once and blocks new ones.
- When power-down is released, a new sequence starts by itself.

A half-scale test flag points every conversion at the reference instead of a channel.

Top module: `dsconv_seq`

## Requirements
- R1: After reset, status_n_o is 1 and hold_o, conv_start_o, load1_o and load2_o are all 0.
- R2: With the start pulse sampled at clock edge k, hold_o is high for exactly one cycle, the cycle after edge k+ACQ_CYCLES-1, and conv_start_o is high in the following cycle.
- R3: With dual_i = 0 at the start, one conversion of CONV_CYCLES cycles runs on ch_a_i. load1_o pulses once, in its last cycle, and load2_o stays 0.
- R4: With dual_i = 1 at the start, a second conversion on ch_b_i begins in the cycle after load1_o (conv_start_o again) and ends with a single load2_o pulse CONV_CYCLES cycles later.
- R5: With irq_mode_i = 0, status_n_o is 0 from the cycle after the start edge until the last conversion cycle, including the boundary between the two conversions of a dual sequence, and 1 afterwards.
- R6: With irq_mode_i = 1, status_n_o stays 1 during a sequence. It goes to 0 in the cycle after the final load strobe, and it stays 0 until a wr_start_i or rd_i pulse, after which it is 1.
- R7: A start pulse during a running sequence cancels it with no load strobe and begins a fresh acquisition from the new control fields. The timing of R2–R4 then counts from that pulse.
- R8: A rd_i pulse during a running sequence returns the block to idle with no further hold or load strobe. In busy mode status_n_o returns to 1.
- R9: While pdn_i is 1, any running sequence stops at the next edge, start pulses are ignored, no strobe is issued and, in busy mode, status_n_o is 1.
- R10: When pdn_i falls, a sequence starts at the next edge without any start pulse, with the R2–R4 timing and the current dual_i.
- R11: With half_i = 1 at the start, ref_o is 1 and chan_o is 0 during every conversion regardless of ch_a_i and ch_b_i, while dual_i still selects one or two conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_start_i | input | 1 | One-cycle pulse: a control write completed |
| rd_i | input | 1 | One-cycle pulse: a host read of a result |
| pdn_i | input | 1 | Power-down level from the control register |
| irq_mode_i | input | 1 | 0: busy status, 1: latched interrupt status |
| dual_i | input | 1 | 1: two sequential conversions per sequence |
| half_i | input | 1 | 1: convert the reference (half-scale test) |
| ch_a_i | input | CH_W | Channel of the first conversion |
| ch_b_i | input | CH_W | Channel of the second conversion |
| hold_o | output | 1 | Hold strobe ending acquisition |
| conv_start_o | output | 1 | First cycle of each conversion |
| chan_o | output | CH_W | Channel of the current conversion |
| ref_o | output | 1 | Reference selected as conversion source |
| load1_o | output | 1 | Load result register 1 |
| load2_o | output | 1 | Load result register 2 |
| status_n_o | output | 1 | Active-low busy or interrupt status |

## Verification
The bench uses the default ACQ_CYCLES = 5, CONV_CYCLES = 14 and CH_W = 3. With these values a complete dual sequence lasts 33 cycles, so every strobe, including the second load, falls inside a 64-cycle recording window and can be located by index. Three-bit channel fields allow distinct nonzero codes on both channel inputs. This makes a swapped first and second channel visible, and it shows that half-scale test mode forces the channel output to zero.

// File: rtl/dsconv_pkg.sv
package dsconv_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_ACQ   = 3'd1,
    SQ_CONV1 = 3'd2,
    SQ_CONV2 = 3'd3,
    SQ_PDN   = 3'd4
  } seq_state_t;

  // larger of two phase lengths, sizes the shared phase counter
  function automatic int unsigned max_len(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // counter value seen in the final cycle of a phase of the given length
  function automatic int unsigned last_count(input int unsigned len);
    return len - 1;
  endfunction

endpackage

// File: rtl/dsconv_phase_ctr.sv
module dsconv_phase_ctr #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end

  // R2: a cleared counter always restarts from zero
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/dsconv_status.sv
module dsconv_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_mode_i,
  input  logic active_i,
  input  logic done_i,
  input  logic clear_i,
  output logic status_n_o
);

  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_q <= 1'b0;
    else if (clear_i) irq_q <= 1'b0;
    else if (done_i)  irq_q <= 1'b1;
  end

  assign status_n_o = irq_mode_i ? ~irq_q : ~active_i;

  // R6
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !clear_i && irq_mode_i) |=> (!irq_mode_i || !status_n_o));

  // R6
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_mode_i && !status_n_o && !clear_i) |=> (!irq_mode_i || !status_n_o));

  // R6
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && irq_mode_i) |=> (!irq_mode_i || status_n_o));

endmodule

// File: rtl/dsconv_chan_sel.sv
module dsconv_chan_sel #(
  parameter int unsigned CH_W = 3
) (
  input  logic            half_i,
  input  logic            second_i,
  input  logic [CH_W-1:0] ch_a_i,
  input  logic [CH_W-1:0] ch_b_i,
  output logic [CH_W-1:0] chan_o,
  output logic            ref_o
);

  always_comb begin
    ref_o  = half_i;
    chan_o = '0;
    if (!half_i) chan_o = second_i ? ch_b_i : ch_a_i;
  end

endmodule

// File: rtl/dsconv_seq.sv
module dsconv_seq
  import dsconv_pkg::*;
#(
  parameter int unsigned ACQ_CYCLES  = 5,
  parameter int unsigned CONV_CYCLES = 14,
  parameter int unsigned CH_W        = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_start_i,
  input  logic            rd_i,
  input  logic            pdn_i,
  input  logic            irq_mode_i,
  input  logic            dual_i,
  input  logic            half_i,
  input  logic [CH_W-1:0] ch_a_i,
  input  logic [CH_W-1:0] ch_b_i,
  output logic            hold_o,
  output logic            conv_start_o,
  output logic [CH_W-1:0] chan_o,
  output logic            ref_o,
  output logic            load1_o,
  output logic            load2_o,
  output logic            status_n_o
);

  localparam int unsigned LEN_MAX = max_len(ACQ_CYCLES, CONV_CYCLES);
  localparam int unsigned CNT_W   = $clog2(LEN_MAX + 1);
  localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(last_count(ACQ_CYCLES));
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(last_count(CONV_CYCLES));

  seq_state_t state_q, state_d;
  logic [CNT_W-1:0] cnt;
  logic [CH_W-1:0]  cfg_ch_a, cfg_ch_b;
  logic             cfg_dual, cfg_half;

  // named internal events
  logic seq_active, start_evt, kill, acq_last, conv_last, in_conv;
  logic seq_done, ctr_clr;

  assign seq_active = (state_q == SQ_ACQ) || (state_q == SQ_CONV1) || (state_q == SQ_CONV2);
  assign in_conv    = (state_q == SQ_CONV1) || (state_q == SQ_CONV2);
  assign start_evt  = !pdn_i && ((state_q == SQ_PDN) || wr_start_i);
  assign kill       = pdn_i || start_evt || rd_i;
  assign acq_last   = (state_q == SQ_ACQ) && (cnt == ACQ_LAST);
  assign conv_last  = in_conv && (cnt == CONV_LAST);

  always_comb begin
    state_d = state_q;
    if (pdn_i)                      state_d = SQ_PDN;
    else if (start_evt)             state_d = SQ_ACQ;
    else if (rd_i && seq_active)    state_d = SQ_IDLE;
    else begin
      unique case (state_q)
        SQ_ACQ:   if (acq_last)  state_d = SQ_CONV1;
        SQ_CONV1: if (conv_last) state_d = cfg_dual ? SQ_CONV2 : SQ_IDLE;
        SQ_CONV2: if (conv_last) state_d = SQ_IDLE;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SQ_IDLE;
      cfg_ch_a <= '0;
      cfg_ch_b <= '0;
      cfg_dual <= 1'b0;
      cfg_half <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_evt) begin
        cfg_ch_a <= ch_a_i;
        cfg_ch_b <= ch_b_i;
        cfg_dual <= dual_i;
        cfg_half <= half_i;
      end
    end
  end

  assign ctr_clr = start_evt || (state_d != state_q);

  dsconv_phase_ctr #(.W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctr_clr),
    .en_i   (seq_active),
    .cnt_o  (cnt)
  );

  assign hold_o       = acq_last && !kill;
  assign conv_start_o = in_conv && (cnt == '0) && !kill;
  assign load1_o      = (state_q == SQ_CONV1) && conv_last && !kill;
  assign load2_o      = (state_q == SQ_CONV2) && conv_last && !kill;
  assign seq_done     = (load1_o && !cfg_dual) || load2_o;

  dsconv_chan_sel #(.CH_W(CH_W)) u_sel (
    .half_i   (cfg_half),
    .second_i (state_q == SQ_CONV2),
    .ch_a_i   (cfg_ch_a),
    .ch_b_i   (cfg_ch_b),
    .chan_o   (chan_o),
    .ref_o    (ref_o)
  );

  dsconv_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_mode_i (irq_mode_i),
    .active_i   (seq_active),
    .done_i     (seq_done),
    .clear_i    (wr_start_i || rd_i),
    .status_n_o (status_n_o)
  );

  // R2
  hold_then_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> (conv_start_o || pdn_i || wr_start_i || rd_i));

  // R3
  loads_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load1_o && load2_o));

  // R4
  load2_dual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load2_o |-> cfg_dual);

  // R7
  restart_acq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_start_i && !pdn_i) |=> ((state_q == SQ_ACQ) && (cnt == '0)));

  // R8
  read_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !pdn_i && !wr_start_i && seq_active) |=> !seq_active);

  // R9
  pdn_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_i |=> (!seq_active && !hold_o && !load1_o && !load2_o));

  // R10
  pdn_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == SQ_PDN) && !pdn_i) |=> (state_q == SQ_ACQ));

endmodule

// File: tb/dsconv_seq_tb_top.sv
module dsconv_seq_tb_top;

  localparam int ACQ  = 5;
  localparam int CONV = 14;
  localparam int CHW  = 3;
  localparam int L1   = ACQ + CONV - 1;      // index of load1
  localparam int L2   = ACQ + 2*CONV - 1;    // index of load2

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0, pdn = 1'b0, irqm = 1'b0, dual = 1'b0, half = 1'b0;
  logic [CHW-1:0] cha = '0, chb = '0;
  logic hold, cst, ref_s, l1, l2, st_n;
  logic [CHW-1:0] chan;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic          r_st  [0:63];
  logic          r_ref [0:63];
  logic [CHW-1:0] r_ch [0:63];
  int n_hold, i_hold, n_cs, i_cs2, n_l1, i_l1, n_l2, i_l2;

  always #2.5 clk = ~clk;

  dsconv_seq #(.ACQ_CYCLES(ACQ), .CONV_CYCLES(CONV), .CH_W(CHW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_start_i(wr), .rd_i(rd), .pdn_i(pdn),
    .irq_mode_i(irqm), .dual_i(dual), .half_i(half), .ch_a_i(cha), .ch_b_i(chb),
    .hold_o(hold), .conv_start_o(cst), .chan_o(chan), .ref_o(ref_s),
    .load1_o(l1), .load2_o(l2), .status_n_o(st_n));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic watch(input int n);
    n_hold = 0; i_hold = -1; n_cs = 0; i_cs2 = -1;
    n_l1 = 0; i_l1 = -1; n_l2 = 0; i_l2 = -1;
    for (int i = 0; i < n; i++) begin
      r_st[i] = st_n; r_ref[i] = ref_s; r_ch[i] = chan;
      if (hold) begin n_hold++; if (i_hold < 0) i_hold = i; end
      if (cst)  begin n_cs++;   if (n_cs == 2) i_cs2 = i; end
      if (l1)   begin n_l1++;   if (i_l1 < 0) i_l1 = i; end
      if (l2)   begin n_l2++;   if (i_l2 < 0) i_l2 = i; end
      @(negedge clk);
    end
  endtask

  task automatic pulse_wr();
    wr = 1'b1; @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse_rd();
    rd = 1'b1; @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 status", int'(st_n), 1);
    check("R1 strobes", int'(hold | cst | l1 | l2), 0);
  endtask

  task automatic t_single_busy();
    irqm = 0; dual = 0; half = 0; cha = 3'd5; chb = 3'd2;
    pulse_wr(); watch(24);
    check("R2 hold count", n_hold, 1);
    check("R2 hold index", i_hold, ACQ - 1);
    check("R3 load1 index", i_l1, L1);
    check("R3 load1 count", n_l1, 1);
    check("R3 no load2", n_l2, 0);
    check("R3 channel", int'(r_ch[10]), 5);
    check("R5 busy first", int'(r_st[0]), 0);
    check("R5 busy last", int'(r_st[L1]), 0);
    check("R5 busy released", int'(r_st[L1 + 1]), 1);
  endtask

  task automatic t_dual_busy();
    irqm = 0; dual = 1; half = 0; cha = 3'd1; chb = 3'd4;
    pulse_wr(); watch(40);
    check("R5 busy across boundary", int'(r_st[L1 + 1]), 0);
    check("R5 busy end", int'(r_st[L2]), 0);
    check("R5 busy released dual", int'(r_st[L2 + 1]), 1);
    check("R4 second conv_start", i_cs2, L1 + 1);
    check("R4 load2 index", i_l2, L2);
    check("R4 load2 count", n_l2, 1);
  endtask

  task automatic t_dual_irq();
    irqm = 1; dual = 1; half = 0; cha = 3'd3; chb = 3'd6;
    pulse_wr(); watch(40);
    check("R4 first channel", int'(r_ch[10]), 3);
    check("R4 second channel", int'(r_ch[L1 + 5]), 6);
    check("R6 high during", int'(r_st[L1 + 1]), 1);
    check("R6 high at load2", int'(r_st[L2]), 1);
    check("R6 low after", int'(r_st[L2 + 1]), 0);
    check("R6 held low", int'(r_st[39]), 0);
    pulse_rd();
    check("R6 cleared by read", int'(st_n), 1);
    irqm = 0;
  endtask

  task automatic t_wr_abort();
    irqm = 0; dual = 0; cha = 3'd2;
    pulse_wr(); watch(10);
    cha = 3'd7;
    pulse_wr();
    check("R7 no load before restart", n_l1 + n_l2, 0);
    watch(24);
    check("R7 restarted hold", i_hold, ACQ - 1);
    check("R7 restarted load1", i_l1, L1);
    check("R7 new channel", int'(r_ch[10]), 7);
    check("R7 busy kept", int'(r_st[0]), 0);
  endtask

  task automatic t_rd_abort();
    irqm = 0; dual = 1; cha = 3'd1;
    pulse_wr(); watch(8);
    pulse_rd(); watch(40);
    check("R8 no strobes", n_hold + n_cs + n_l1 + n_l2, 0);
    check("R8 status high", int'(r_st[0]), 1);
  endtask

  task automatic t_pdn();
    irqm = 0; dual = 1; half = 0; cha = 3'd2; chb = 3'd5;
    pulse_wr(); watch(22);
    pdn = 1'b1; @(negedge clk);
    watch(5);
    pulse_wr(); watch(10);
    check("R9 no strobes", n_hold + n_l1 + n_l2, 0);
    check("R9 status high", int'(r_st[0]), 1);
    pdn = 1'b0; @(negedge clk);
    watch(40);
    check("R10 auto hold", i_hold, ACQ - 1);
    check("R10 auto load1", i_l1, L1);
    check("R10 auto load2", i_l2, L2);
  endtask

  task automatic t_half();
    irqm = 0; dual = 1; half = 1; cha = 3'd5; chb = 3'd6;
    pulse_wr(); watch(40);
    check("R11 ref first", int'(r_ref[10]), 1);
    check("R11 chan zero first", int'(r_ch[10]), 0);
    check("R11 chan zero second", int'(r_ch[L1 + 5]), 0);
    check("R11 dual kept", i_l2, L2);
    half = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_busy();
    t_dual_busy();
    t_dual_irq();
    t_wr_abort();
    t_rd_abort();
    t_pdn();
    t_half();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule